// File: doc/BRIEF.md
# Countdown Watchdog with Configurable Reset Pulse

This block is a byte-programmed watchdog. Software loads an 8-bit count. It picks whether each step of that count lasts one second or one minute, and then starts the countdown. When the count runs out, a sticky timeout flag is raised. If the reset output is enabled, a reset pulse is also emitted. Its length is chosen from four settings and its active level is selectable.

The expected sequence is as follows. Stop the counter, clear the timeout flag, write the count, then write the control byte with the run bit set. While the counter runs, writing the count register again reloads it and restarts the current step. This is how the watchdog is refreshed. All time bases come from the system clock through a clocks-per-millisecond prescaler. Two more parameters set the milliseconds per second and the seconds per minute.

Top module: `wdt_pulse`

## Requirements
- R1: After reset the control byte, count and status all read 0, `timeout` is 0, and `wdt_rst` is 1 (idle for active-low).
- R2: The register at address 0 is control: bit 0 run, bit 1 unit (1 selects minutes), bit 2 reset-output enable, bit 3 polarity (1 means active-high), and bits 5:4 the pulse-width code. It reads back bits 5:0 as written, and bits 7:6 read as 0.
- R3: In seconds mode, with count N nonzero, `timeout` rises exactly N×CLK_PER_MS×MS_PER_SEC cycles after the write that sets run.
- R4: In minutes mode, the interval is N×CLK_PER_MS×MS_PER_SEC×SEC_PER_MIN cycles.
- R5: Address 1 reads the remaining count, which drops by one at the end of each completed step.
- R6: A count of 0 never causes a timeout, even with run set.
- R7: The status bit (address 2, bit 0, also on `timeout`) stays set after the pulse ends. Writing 1 to bit 0 clears it, and writing 0 leaves it set.
- R8: The pulse lasts CLK_PER_MS clocks times 1, 25, 125 or 5×MS_PER_SEC for width codes 00, 01, 10 and 11. It begins in the same cycle that `timeout` rises. Code 00 is too short for reliable resets and should not be used by software.
- R9: With polarity 1 the pulse is high and the output idles low. With polarity 0 the pulse is low and the output idles high.
- R10: With the output enable at 0, expiry sets the status only, and `wdt_rst` stays at its idle level.
- R11: Writing the count register while running reloads the count and restarts timing, so the full interval is measured from that write.
- R12: Clearing run freezes the count. Setting run again resumes from the held value with a fresh step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 count, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| timeout | output | 1 | Sticky expiry flag |
| wdt_rst | output | 1 | Reset pulse output |

## Verification
A write takes effect at the clock edge that samples it. With that edge called E0, a decrement lands at edge E0+k×L, where L is the step length in clocks. Both `timeout` and the start of the pulse are registered at edge E0+N×L. The pulse output then holds its active level for exactly the coded number of clocks. The bench drives and samples on falling edges and counts falling edges from the write. The expiry count must therefore equal N×L, and the pulse count must equal the coded width. The bench parameters shrink the time base so that every width code and both units can be run in full.

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int CLK_PER_MS  = 125000,
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       timeout,
  output logic       wdt_rst
);
  localparam longint SEC_CYC = longint'(CLK_PER_MS) * longint'(MS_PER_SEC);
  localparam longint MIN_CYC = SEC_CYC * longint'(SEC_PER_MIN);
  localparam int     SW      = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
  localparam longint P0      = longint'(CLK_PER_MS);
  localparam longint P1      = 25 * longint'(CLK_PER_MS);
  localparam longint P2      = 125 * longint'(CLK_PER_MS);
  localparam longint P3      = 5 * SEC_CYC;
  localparam longint PMAX    = (P2 > P3) ? P2 : P3;
  localparam int     PW      = $clog2(PMAX + 1);

  logic          run, unit_min, out_en, pol_hi;
  logic [1:0]    width;
  logic [7:0]    cnt;
  logic [SW-1:0] step;
  logic [PW-1:0] pulse_left;
  logic          sts;

  wire wr_ctrl = wr_en && (addr == 2'd0);
  wire wr_cnt  = wr_en && (addr == 2'd1);
  wire wr_sts  = wr_en && (addr == 2'd2);

  wire [SW-1:0] step_last = unit_min ? SW'(MIN_CYC - 1) : SW'(SEC_CYC - 1);
  wire step_done = run && (cnt != 8'd0) && (step >= step_last);
  wire expire    = step_done && (cnt == 8'd1) && !wr_cnt;
  wire pulse_act = (pulse_left != '0);

  logic [PW-1:0] pulse_load;
  always_comb begin
    case (width)
      2'b00:   pulse_load = PW'(P0);
      2'b01:   pulse_load = PW'(P1);
      2'b10:   pulse_load = PW'(P2);
      default: pulse_load = PW'(P3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {width, pol_hi, out_en, unit_min, run} <= '0;
    end else if (wr_ctrl) begin
      {width, pol_hi, out_en, unit_min, run} <= wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                step <= '0;
    else if (wr_cnt || wr_ctrl || !run || cnt == 8'd0 || step_done) step <= '0;
    else                                       step <= step + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (wr_cnt)    cnt <= wdata;
    else if (step_done) cnt <= cnt - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sts <= 1'b0;
    else if (expire)                sts <= 1'b1;
    else if (wr_sts && wdata[0])    sts <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pulse_left <= '0;
    else if (expire && out_en)  pulse_left <= pulse_load;
    else if (pulse_act)         pulse_left <= pulse_left - 1'b1;
  end

  assign timeout = sts;
  assign wdt_rst = pulse_act ? pol_hi : ~pol_hi;

  always_comb begin
    case (addr)
      2'd0:    rdata = {2'b00, width, pol_hi, out_en, unit_min, run};
      2'd1:    rdata = cnt;
      2'd2:    rdata = {7'd0, sts};
      default: rdata = 8'd0;
    endcase
  end

  p_sticky_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts) |-> $past(wr_sts && wdata[0]));

  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cnt) && cnt != $past(cnt)) |-> cnt == $past(cnt) - 8'd1);

  p_expire_from_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> $past(cnt) == 8'd1);

  p_pulse_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_act) |-> ($past(out_en) && cnt == 8'd0));

  p_hold_when_stopped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(wr_cnt)) |-> $stable(cnt));
endmodule

// File: tb/wdt_pulse_tb_top.sv
module wdt_pulse_tb_top;
  localparam int CPM = 2, MPS = 3, SPM = 2;
  localparam int SEC_L = CPM * MPS;
  localparam int MIN_L = SEC_L * SPM;
  localparam int NV = 6;
  // {unit, pol, width[1:0], count[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'b01, 8'd3},
    {1'b0, 1'b1, 2'b10, 8'd1},
    {1'b1, 1'b0, 2'b11, 8'd2},
    {1'b1, 1'b1, 2'b00, 8'd5},
    {1'b0, 1'b0, 2'b00, 8'd255},
    {1'b1, 1'b1, 2'b01, 8'd4}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic timeout, wdt_rst;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wdt_pulse #(.CLK_PER_MS(CPM), .MS_PER_SEC(MPS), .SEC_PER_MIN(SPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .timeout(timeout), .wdt_rst(wdt_rst));

  function automatic int pulse_cyc(input logic [1:0] w);
    case (w)
      2'b00:   return CPM;
      2'b01:   return 25 * CPM;
      2'b10:   return 125 * CPM;
      default: return 5 * MPS * CPM;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic until_timeout(output int c);
    c = 0;
    while (!timeout && c < 5000) begin @(negedge clk); c++; end
  endtask

  task automatic pulse_len(input logic act_lvl, output int p);
    p = 0;
    while (wdt_rst == act_lvl && p < 5000) begin @(negedge clk); p++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired before all requirements were checked");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int c, p;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 count", d, 0);
    rd(2'd2, d); chk("R1 status", d, 0);
    chk("R1 timeout", timeout, 0);
    chk("R1 wdt_rst idle", wdt_rst, 1);

    // R2 control readback
    wr(2'd0, 8'hFA); rd(2'd0, d); chk("R2 ctrl readback", d, 8'h3A);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R2 ctrl cleared", d, 8'h00);

    // vector table: R3 R4 R8 R9 R7
    for (int i = 0; i < NV; i++) begin
      logic u, pl;
      logic [1:0] w;
      logic [7:0] n;
      {u, pl, w, n} = VEC[i];
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h01);
      wr(2'd1, n);
      wr(2'd0, {2'b00, w, pl, 1'b1, u, 1'b1});
      chk("R9 idle level", wdt_rst, !pl);
      until_timeout(c);
      chk(u ? "R4 minute interval" : "R3 second interval", c, n * (u ? MIN_L : SEC_L));
      chk("R9 active level", wdt_rst, pl);
      pulse_len(pl, p);
      chk("R8 pulse width", p, pulse_cyc(w));
      chk("R7 status after pulse", timeout, 1);
      rd(2'd1, d); chk("R5 count at expiry", d, 0);
    end

    // R7 write-one-to-clear
    wr(2'd2, 8'h00); rd(2'd2, d); chk("R7 write 0 keeps", d, 1);
    wr(2'd2, 8'h01); rd(2'd2, d); chk("R7 write 1 clears", d, 0);

    // R6 zero count
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h05);
    wait_cyc(200);
    chk("R6 zero count timeout", timeout, 0);
    chk("R6 zero count output", wdt_rst, 1);

    // R10 output disabled
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd2);
    wr(2'd0, 8'h09);
    c = 0; p = 0;
    while (!timeout && c < 5000) begin
      @(negedge clk); c++;
      if (wdt_rst != 1'b0) p++;
    end
    repeat (20) begin @(negedge clk); if (wdt_rst != 1'b0) p++; end
    chk("R10 status set", c, 2 * SEC_L);
    chk("R10 output stays idle", p, 0);

    // R11 kick
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h05);
    wait_cyc(10);
    wr(2'd1, 8'd4);
    until_timeout(c);
    chk("R11 interval from kick", c, 4 * SEC_L - 1 + 1);
    pulse_len(1'b0, p);

    // R5 R12 readback, stop, resume
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'h05);
    wait_cyc(SEC_L - 1);
    rd(2'd1, d); chk("R5 count before step", d, 5);
    wait_cyc(1);
    rd(2'd1, d); chk("R5 count after step", d, 4);
    wait_cyc(SEC_L + 1);
    rd(2'd1, d); chk("R5 count two steps", d, 3);
    wr(2'd0, 8'h04);
    wait_cyc(30);
    rd(2'd1, d); chk("R12 held count", d, 3);
    chk("R12 no timeout while stopped", timeout, 0);
    wr(2'd0, 8'h05);
    until_timeout(c);
    chk("R12 resume interval", c, 3 * SEC_L);
    pulse_len(1'b0, p);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule